// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block brings up a device's configuration from a three-wire serial EEPROM (Microwire style: select, clock, data-in, data-out). It samples a strap during reset to learn whether an EEPROM is fitted. When one is fitted, the block reads a 68-byte image as 34 sixteen-bit words as soon as reset is released. The first 16 bytes go into a station-address store and the other 52 bytes into 26 configuration words.

An 8-bit checksum over the whole image decides whether the configuration is kept or forced back to its defaults. The station address is kept either way. While the image is loading, a busy output tells the host bus interface to answer every access with a retry.

Once the block is idle, a small software register drives the EEPROM pins directly and reads back the EEPROM's data line. Software uses it to program the part.

Top module: `ee_autoload`

## Requirements
- R1: The EEPROM-present strap `ee_sk_i` is sampled at the last rising clock edge with `rst_ni` low: 1 means present and 0 means absent. When present, the load starts on the first clock after reset release.
- R2: Each word is read with one select window. The command is 9 bits on `ee_di_o`, taken by the EEPROM on rising `ee_sk_o`: start bit 1, opcode `10`, then a 6-bit word address, MSB first. Addresses run in ascending order from 0 to 33.
- R3: Within a select window, data is sampled from `ee_do_i` on rising `ee_sk_o` edges 10 to 25, MSB first. `ee_cs_o` drops between words, and `ee_sk_o` is never high while `ee_cs_o` is low during a load.
- R4: Each high and each low phase of `ee_sk_o` lasts `SK_HALF` system clocks (default 2).
- R5: Word w (w < 8) fills station bytes 2w (low byte) and 2w+1 (high byte). Byte k is `station_addr_o[8k+7:8k]`.
- R6: Word 8+j fills configuration word j, which is `cfg_o[16j+15:16j]`, for j = 0 to 25.
- R7: If the 8-bit sum of all 68 bytes equals FFh, the load ends with `sw_rdata_o[15]` (valid) = 1 and `sw_rdata_o[14]` (read done) = 1.
- R8: On a checksum mismatch, valid = 0 and read done = 1. Every configuration word j returns to its default `{8'hC0+j, 8'h3C^j}`, and the station bytes keep their loaded values.
- R9: With no EEPROM present, no select window occurs. Read done and valid stay 0, and all configuration words hold their defaults.
- R10: `busy_o` is high from the release of reset until the load ends, and read done stays 0 meanwhile. After the load ends, `busy_o` is low. With no EEPROM present, `busy_o` is low from the first clock after release.
- R11: When idle, a write with `sw_we_i` stores `sw_wdata_i` as {cs, sk, di} in bits 2,1,0. These bits drive `ee_cs_o`, `ee_sk_o` and `ee_di_o`. `sw_rdata_o[2:0]` reads them back, and `sw_rdata_o[3]` reads `ee_do_i`.
- R12: A software write while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ee_sk_i | input | 1 | Level of the shared clock pin, used as the presence strap in reset |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| sw_we_i | input | 1 | Software pin register write strobe |
| sw_wdata_i | input | 3 | Software pin values {cs, sk, di} |
| sw_rdata_o | output | 16 | Status and pin readback |
| busy_o | output | 1 | Load in progress; host accesses are retried |
| station_addr_o | output | 128 | Station address bytes |
| cfg_o | output | 416 | Configuration words |

## Verification
The bench models the EEPROM at the pin level. It answers only when a command arrives with the correct start bit, opcode and next address, so a design that misorders bits or skips a word returns wrong data or counts command errors. A sweep of the checksum byte around its passing value checks that exactly one value sets valid. A design that compared the sum wrongly, or that also restored the station address on failure, would show wrong flags or lost bytes. The absent-strap case catches a design that still selects the EEPROM or raises read done. A software write made during a load catches a design that leaks pin control out of idle.

// File: rtl/ee_autoload_pkg.sv
package ee_autoload_pkg;
  function automatic logic [15:0] cfg_dflt(int unsigned j);
    return {8'hC0 + 8'(j), 8'h3C ^ 8'(j)};
  endfunction
endpackage

// File: rtl/ee_clk_div.sv
module ee_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_mw_reader.sv
module ee_mw_reader #(
  parameter int WORDS = 34,
  parameter int AW    = 6,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          ee_do_i,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o,
  output logic          run_o,
  output logic          word_vld_o,
  output logic [AW-1:0] word_idx_o,
  output logic [DW-1:0] word_o,
  output logic          done_o
);
  localparam int CMD_BITS = 3 + AW;
  localparam int FRAME    = CMD_BITS + DW;
  localparam int BW       = $clog2(FRAME + 1);

  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_DESEL} rd_st_e;

  rd_st_e          st_q;
  logic            cs_q, sk_q, vld_q, done_q;
  logic [BW-1:0]   bit_q;
  logic [AW-1:0]   idx_q;
  logic [DW-1:0]   sh_q;
  logic [CMD_BITS-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RD_IDLE; cs_q <= 1'b0; sk_q <= 1'b0; vld_q <= 1'b0; done_q <= 1'b0;
      bit_q <= '0; idx_q <= '0; sh_q <= '0; cmd_q <= '0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        RD_IDLE: if (start_i) begin
          st_q  <= RD_SHIFT;
          cs_q  <= 1'b1;
          bit_q <= '0;
          idx_q <= '0;
          cmd_q <= {3'b110, {AW{1'b0}}};
        end
        RD_SHIFT: if (tick_i) begin
          if (!sk_q) begin
            sk_q <= 1'b1;
            if (bit_q >= BW'(CMD_BITS)) sh_q <= {sh_q[DW-2:0], ee_do_i};
          end else begin
            sk_q  <= 1'b0;
            cmd_q <= cmd_q << 1;
            if (bit_q == BW'(FRAME - 1)) begin
              cs_q  <= 1'b0;
              vld_q <= 1'b1;
              st_q  <= RD_DESEL;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        RD_DESEL: if (tick_i) begin
          if (idx_q == AW'(WORDS - 1)) begin
            st_q   <= RD_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            cmd_q <= {3'b110, idx_q + 1'b1};
            bit_q <= '0;
            cs_q  <= 1'b1;
            st_q  <= RD_SHIFT;
          end
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign cs_o       = cs_q;
  assign sk_o       = sk_q;
  assign di_o       = cs_q & cmd_q[CMD_BITS-1];
  assign run_o      = (st_q != RD_IDLE);
  assign word_vld_o = vld_q;
  assign word_idx_o = idx_q;
  assign word_o     = sh_q;
  assign done_o     = done_q;

  AST_SK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_q |-> cs_q); // R3
  AST_SK_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sk_q)); // R4
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < AW'(WORDS)); // R2
endmodule

// File: rtl/ee_cfg_store.sv
module ee_cfg_store
  import ee_autoload_pkg::*;
#(
  parameter int ADDR_WORDS = 8,
  parameter int CFG_WORDS  = 26,
  parameter int AW         = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      word_vld_i,
  input  logic [AW-1:0]             word_idx_i,
  input  logic [15:0]               word_i,
  input  logic                      done_i,
  output logic [ADDR_WORDS*16-1:0]  station_o,
  output logic [CFG_WORDS*16-1:0]   cfg_o,
  output logic                      rd_done_o,
  output logic                      valid_o
);
  function automatic logic [CFG_WORDS*16-1:0] dflt_vec();
    logic [CFG_WORDS*16-1:0] v;
    for (int c = 0; c < CFG_WORDS; c++) v[16*c +: 16] = cfg_dflt(c);
    return v;
  endfunction
  localparam logic [CFG_WORDS*16-1:0] CFG_RST = dflt_vec();

  logic [ADDR_WORDS*16-1:0] station_q;
  logic [CFG_WORDS*16-1:0]  cfg_q;
  logic [7:0]               sum_q;
  logic                     rd_done_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      station_q <= '0;
      cfg_q     <= CFG_RST;
      sum_q     <= '0;
      rd_done_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      if (word_vld_i) begin
        sum_q <= sum_q + word_i[7:0] + word_i[15:8];
        for (int w = 0; w < ADDR_WORDS; w++)
          if (word_idx_i == AW'(w)) station_q[16*w +: 16] <= word_i;
        for (int c = 0; c < CFG_WORDS; c++)
          if (word_idx_i == AW'(ADDR_WORDS + c)) cfg_q[16*c +: 16] <= word_i;
      end
      if (done_i) begin
        rd_done_q <= 1'b1;
        valid_q   <= (sum_q == 8'hFF);
        if (sum_q != 8'hFF) cfg_q <= CFG_RST;
      end
    end
  end

  assign station_o = station_q;
  assign cfg_o     = cfg_q;
  assign rd_done_o = rd_done_q;
  assign valid_o   = valid_q;

  AST_VALID_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> rd_done_q); // R7
  AST_FAIL_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_q && !valid_q) |-> (cfg_q == CFG_RST)); // R8
endmodule

// File: rtl/ee_autoload.sv
module ee_autoload #(
  parameter int IMG_BYTES  = 68,
  parameter int ADDR_BYTES = 16,
  parameter int SK_HALF    = 2,
  parameter int AW         = 6
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  ee_sk_i,
  input  logic                                  ee_do_i,
  output logic                                  ee_cs_o,
  output logic                                  ee_sk_o,
  output logic                                  ee_di_o,
  input  logic                                  sw_we_i,
  input  logic [2:0]                            sw_wdata_i,
  output logic [15:0]                           sw_rdata_o,
  output logic                                  busy_o,
  output logic [ADDR_BYTES*8-1:0]               station_addr_o,
  output logic [(IMG_BYTES-ADDR_BYTES)*8-1:0]   cfg_o
);
  localparam int WORDS      = IMG_BYTES / 2;
  localparam int ADDR_WORDS = ADDR_BYTES / 2;
  localparam int CFG_WORDS  = (IMG_BYTES - ADDR_BYTES) / 2;

  logic          present_q, boot_q;
  logic [2:0]    sw_q;
  logic          tick, rd_run, rd_cs, rd_sk, rd_di, word_vld, rd_fin;
  logic [AW-1:0] word_idx;
  logic [15:0]   word;
  logic          rd_done, valid;

  // strap follows the pin while reset is held; last edge in reset wins
  always_ff @(posedge clk_i) begin
    if (!rst_ni) present_q <= ee_sk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      sw_q   <= '0;
    end else begin
      boot_q <= 1'b0;
      if (sw_we_i && !busy_o) sw_q <= sw_wdata_i;
    end
  end

  assign busy_o = (boot_q & present_q) | rd_run;

  ee_clk_div #(.HALF(SK_HALF)) u_div (
    .clk_i, .rst_ni, .en_i(rd_run), .tick_o(tick)
  );

  ee_mw_reader #(.WORDS(WORDS), .AW(AW), .DW(16)) u_rd (
    .clk_i, .rst_ni,
    .start_i    (boot_q & present_q),
    .tick_i     (tick),
    .ee_do_i,
    .cs_o       (rd_cs),
    .sk_o       (rd_sk),
    .di_o       (rd_di),
    .run_o      (rd_run),
    .word_vld_o (word_vld),
    .word_idx_o (word_idx),
    .word_o     (word),
    .done_o     (rd_fin)
  );

  ee_cfg_store #(.ADDR_WORDS(ADDR_WORDS), .CFG_WORDS(CFG_WORDS), .AW(AW)) u_st (
    .clk_i, .rst_ni,
    .word_vld_i (word_vld),
    .word_idx_i (word_idx),
    .word_i     (word),
    .done_i     (rd_fin),
    .station_o  (station_addr_o),
    .cfg_o      (cfg_o),
    .rd_done_o  (rd_done),
    .valid_o    (valid)
  );

  assign ee_cs_o    = rd_run ? rd_cs : sw_q[2];
  assign ee_sk_o    = rd_run ? rd_sk : sw_q[1];
  assign ee_di_o    = rd_run ? rd_di : sw_q[0];
  assign sw_rdata_o = {valid, rd_done, 10'b0, ee_do_i, sw_q};

  AST_SW_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sw_we_i) |=> $stable(sw_q)); // R12
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |-> !busy_o); // R10
  AST_ABSENT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_q |-> !rd_run); // R9
endmodule

// File: tb/sim_ee_autoload.sv
`timescale 1ns/1ps
module sim_ee_autoload;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic ee_do, cs, sk, di, sw_we = 1'b0, busy;
  logic [2:0] sw_wd = '0;
  logic [15:0] rdata;
  logic [127:0] station;
  logic [415:0] cfg;

  int nchk = 0, nbad = 0;
  logic [7:0]  img [68];
  logic [15:0] mem [64];
  int sk_cnt = 0, reads = 0, cmd_err = 0, next_addr = 0;
  logic [8:0] cmd_rx = '0;
  logic do_force = 1'b0;
  int hi_run = 0, last_hi = 0;

  always #2 clk = ~clk;

  ee_autoload u0 (
    .clk_i(clk), .rst_ni(rst_n), .ee_sk_i(strap), .ee_do_i(ee_do),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di),
    .sw_we_i(sw_we), .sw_wdata_i(sw_wd), .sw_rdata_o(rdata),
    .busy_o(busy), .station_addr_o(station), .cfg_o(cfg)
  );

  // pin-level EEPROM model
  always @(negedge cs) sk_cnt = 0;
  always @(posedge sk) if (cs) begin
    sk_cnt = sk_cnt + 1;
    if (sk_cnt <= 9) cmd_rx = {cmd_rx[7:0], di};
    if (sk_cnt == 9) begin
      reads = reads + 1;
      if (cmd_rx[8:6] != 3'b110 || int'(cmd_rx[5:0]) != next_addr) cmd_err = cmd_err + 1;
      next_addr = next_addr + 1;
    end
  end
  assign ee_do = do_force ? 1'b1 :
                 (sk_cnt >= 9 && sk_cnt < 25) ? mem[cmd_rx[5:0]][24 - sk_cnt] : 1'b0;

  always @(posedge clk) begin
    if (sk) hi_run = hi_run + 1;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  task automatic check(input bit ok, input string msg);
    nchk++;
    if (!ok) begin nbad++; $display("FAIL %s", msg); end
  endtask

  function automatic logic [15:0] dflt(int j);
    return {8'(8'hC0 + j), 8'(8'h3C ^ j)};
  endfunction

  task automatic sw_write(input logic [2:0] v);
    @(negedge clk); sw_we = 1'b1; sw_wd = v;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic run_load(input bit present, input int seed, input int delta, input bit poke);
    int s;
    bit pass;
    s = 0;
    for (int b = 0; b < 67; b++) begin
      img[b] = 8'(seed * 37 + b * 13 + 5);
      s += int'(img[b]);
    end
    img[67] = 8'(8'hFF - s + delta);
    pass = (delta == 0);
    for (int a = 0; a < 64; a++) mem[a] = (a < 34) ? {img[2*a+1], img[2*a]} : 16'h0;
    reads = 0; cmd_err = 0; next_addr = 0;
    @(negedge clk); rst_n = 1'b0; strap = present;
    repeat (4) @(negedge clk);
    check(rdata[15:14] == 2'b00 && cs == 1'b0,
          $sformatf("R10 reset state rdata=%h cs=%b exp flags 0 cs 0", rdata, cs));
    rst_n = 1'b1; strap = 1'b0;
    @(negedge clk);
    check(busy == present, $sformatf("R1 busy after release act=%b exp=%b", busy, present));
    repeat (10) @(negedge clk);
    check(busy == present && rdata[14] == 1'b0,
          $sformatf("R10 busy during load act=%b done=%b exp busy=%b done=0", busy, rdata[14], present));
    if (poke) begin
      sw_write(3'b111);
      check(busy == 1'b1, "R12 poke issued while busy");
    end
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, $sformatf("R10 busy after load act=%b exp=0", busy));
    if (present) begin
      check(reads == 34 && cmd_err == 0,
            $sformatf("R2 reads=%0d cmd_err=%0d exp 34/0", reads, cmd_err));
      check(last_hi == 2, $sformatf("R4 sk high width act=%0d exp=2", last_hi));
      for (int k = 0; k < 16; k++)
        check(station[8*k +: 8] == img[k],
              $sformatf("R5 station byte %0d act=%h exp=%h", k, station[8*k +: 8], img[k]));
      for (int j = 0; j < 26; j++) begin
        logic [15:0] e;
        e = pass ? {img[17+2*j], img[16+2*j]} : dflt(j);
        check(cfg[16*j +: 16] == e,
              $sformatf("%s cfg word %0d act=%h exp=%h", pass ? "R6" : "R8", j, cfg[16*j +: 16], e));
      end
      check(rdata[15:14] == {pass, 1'b1},
            $sformatf("%s flags act=%b exp=%b", pass ? "R7" : "R8", rdata[15:14], {pass, 1'b1}));
    end else begin
      check(reads == 0, $sformatf("R9 reads act=%0d exp=0", reads));
      check(rdata[15:14] == 2'b00, $sformatf("R9 flags act=%b exp=00", rdata[15:14]));
      for (int j = 0; j < 26; j++)
        check(cfg[16*j +: 16] == dflt(j),
              $sformatf("R9 cfg word %0d act=%h exp=%h", j, cfg[16*j +: 16], dflt(j)));
    end
    if (poke)
      check(rdata[2:0] == 3'b000 && cs == 1'b0 && sk == 1'b0,
            $sformatf("R12 sw bits act=%b pins=%b%b exp 000", rdata[2:0], cs, sk));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nbad++; nchk++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    run_load(1'b1, 1, 0, 1'b1);
    run_load(1'b1, 2, 0, 1'b0);
    for (int d = 1; d < 6; d++) run_load(1'b1, 3 + d, d, 1'b0);
    run_load(1'b1, 9, 255, 1'b0);
    run_load(1'b0, 4, 0, 1'b0);
    // R11 software pin access while idle
    for (int v = 0; v < 8; v++) begin
      sw_write(3'(v));
      @(negedge clk);
      check({cs, sk, di} == 3'(v) && rdata[2:0] == 3'(v),
            $sformatf("R11 pins act=%b%b%b rd=%b exp=%b", cs, sk, di, rdata[2:0], 3'(v)));
    end
    do_force = 1'b1; @(negedge clk);
    check(rdata[3] == 1'b1, $sformatf("R11 data-in readback act=%b exp=1", rdata[3]));
    do_force = 1'b0; sw_write(3'b000); @(negedge clk);
    check(rdata[3] == 1'b0, $sformatf("R11 data-in readback act=%b exp=0", rdata[3]));
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule